// File: doc/BRIEF.md
# Load Replay Queue Selector

This block keeps a small pool of stalled load operations that must go back through the load pipeline, and chooses one of them at a time to reissue. Each slot stores the load's circular queue index (index bits plus a wrap bit), a two-bit replay cause, a ready flag set by a per-slot wakeup, and an in-flight flag. A slot that has been reissued stays allocated and in flight until its replay outcome arrives. The outcome either re-arms the slot for another wait-and-replay round or releases it.

The pick follows a fixed priority. First comes a pointer window. The oldest outstanding load pointer plus offsets 0 to WIN-1 is compared with every eligible slot's index, and the lowest matching offset wins, so an exact match on the pointer always wins. WIN is meant to exceed the load pipeline depth. Without a window hit, eligible slots whose cause is data-not-ready come next, with the oldest by first enqueue chosen through an age matrix. Last come all other eligible slots, again oldest first. The bank a load targets plays no part in the choice.

A two-state machine owns the issue port. In S_IDLE it waits while nothing is eligible (wait). When a slot is eligible it captures the pick and moves to S_OFFER (pick). In S_OFFER it holds the offer while the consumer stalls (hold), and it returns to S_IDLE when the offer is accepted (accept). A flush sends either state to S_IDLE (flush), empties every slot and clears the age matrix.

Top module: `ldrpl_sel`

## Requirements
- R1: An enqueue writes the lowest-numbered free slot. enq_ready is high exactly when at least one slot is free, and an enqueue while enq_ready is low is dropped.
- R2: Accepting an offer (iss_valid and iss_ready both high) marks the slot in flight but does not free it, so enq_ready stays low in a full pool.
- R3: A replay result with res_replay=1 clears the slot's in-flight and ready flags and stores res_cause, so the slot is offered again only after a new wakeup. A result with res_replay=0 frees the slot.
- R4: With no window hit and no cause difference, the eligible slot enqueued earliest is offered, including when it becomes ready after younger slots.
- R5: An eligible slot whose full index, wrap bit included, equals oldest_ptr is offered ahead of any older slot.
- R6: Within the window, a lower offset from oldest_ptr beats a higher one, and the offset is computed modulo 2^(IDX_W+1), so the window wraps across the wrap-bit boundary.
- R7: Outside the window, an eligible slot with cause code 0 (data not ready) is offered ahead of older slots with cause codes 1 to 3.
- R8: While iss_valid is high and iss_ready is low, iss_slot and iss_idx stay constant and iss_valid stays high.
- R9: During a flush cycle iss_valid is low. After the flush every slot is free, and wakeups make nothing eligible.
- R10: A wakeup to a slot that is in flight, or to a free slot, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the pool and clears the age matrix |
| enq_valid | input | 1 | Enqueue request |
| enq_idx | input | IDX_W+1 | Circular load-queue index of the new entry (MSB is the wrap bit) |
| enq_cause | input | 2 | Replay cause of the new entry (0 = data not ready) |
| enq_ready | output | 1 | At least one slot is free |
| wake | input | DEPTH | Per-slot wakeup that sets the ready flag |
| res_valid | input | 1 | Replay outcome is present |
| res_slot | input | log2(DEPTH) | Slot that the outcome refers to |
| res_replay | input | 1 | 1 re-arms the slot, 0 frees it |
| res_cause | input | 2 | New cause stored when the slot is re-armed |
| oldest_ptr | input | IDX_W+1 | Index of the oldest outstanding load |
| iss_valid | output | 1 | An offer is presented |
| iss_ready | input | 1 | The load pipeline takes the offer |
| iss_slot | output | log2(DEPTH) | Slot being offered |
| iss_idx | output | IDX_W+1 | Queue index of the offered slot |

## Verification
The sharpest case has the slot at offset 0 in a higher-numbered position than slots at offsets 1 to 3. An encoder that scanned the mask the wrong way would hand out a younger load and could starve the oldest one. Other rows put the window across the wrap-bit boundary, or give two slots the same index bits but different wrap bits. A design that drops the wrap bit offers the wrong slot in those rows. Directed runs wake the oldest slot only after its younger neighbours, and the bench then expects it next and expects a stalled offer to hold still. A design that frees a slot on issue, or that reissues a re-armed slot without a wakeup, shows up as enq_ready rising too early or as an unexpected offer.

// File: rtl/ldrpl_pkg.sv
package ldrpl_pkg;
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } sel_state_t;

    localparam logic [1:0] CAUSE_DATA = 2'd0;
endpackage

// File: rtl/ldrpl_age.sv
module ldrpl_age #(
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              enq_fire,
    input  logic [SLOT_W-1:0] enq_slot,
    input  logic [DEPTH-1:0]  valid_vec,
    input  logic [DEPTH-1:0]  free_vec,
    input  logic [DEPTH-1:0]  mask_data,
    input  logic [DEPTH-1:0]  mask_any,
    output logic [DEPTH-1:0]  hot_data,
    output logic [DEPTH-1:0]  hot_any
);
    // older[i][j] set: slot i entered before slot j
    logic [DEPTH-1:0][DEPTH-1:0] older;
    logic [DEPTH-1:0][DEPTH-1:0] col;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            older <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (free_vec[i] || free_vec[j])
                        older[i][j] <= 1'b0;
                    else if (enq_fire && SLOT_W'(i) == enq_slot)
                        older[i][j] <= 1'b0;
                    else if (enq_fire && SLOT_W'(j) == enq_slot)
                        older[i][j] <= valid_vec[i];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < DEPTH; j++)
                col[i][j] = older[j][i];
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_pick
            assign hot_data[g] = mask_data[g] & ~|(mask_data & col[g]);
            assign hot_any[g]  = mask_any[g]  & ~|(mask_any  & col[g]);
        end
    endgenerate
endmodule

// File: rtl/ldrpl_win.sv
module ldrpl_win #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 4,
    parameter int WIN    = 4,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int QW     = IDX_W + 1
) (
    input  logic [DEPTH-1:0]         elig,
    input  logic [DEPTH-1:0][QW-1:0] ent_idx,
    input  logic [QW-1:0]            oldest_ptr,
    output logic                     hit,
    output logic [SLOT_W-1:0]        slot
);
    logic [WIN-1:0][QW-1:0] target;

    generate
        for (genvar k = 0; k < WIN; k++) begin : g_off
            assign target[k] = oldest_ptr + QW'(k);
        end
    endgenerate

    // scanned from the far end so offset 0 and the lowest slot land last
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int k = WIN - 1; k >= 0; k--) begin
            for (int s = DEPTH - 1; s >= 0; s--) begin
                if (elig[s] && ent_idx[s] == target[k]) begin
                    hit  = 1'b1;
                    slot = SLOT_W'(s);
                end
            end
        end
    end
endmodule

// File: rtl/ldrpl_sel.sv
module ldrpl_sel
    import ldrpl_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 4,
    parameter int WIN    = 4,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int QW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              enq_valid,
    input  logic [QW-1:0]     enq_idx,
    input  logic [1:0]        enq_cause,
    output logic              enq_ready,
    input  logic [DEPTH-1:0]  wake,
    input  logic              res_valid,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic              res_replay,
    input  logic [1:0]        res_cause,
    input  logic [QW-1:0]     oldest_ptr,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [SLOT_W-1:0] iss_slot,
    output logic [QW-1:0]     iss_idx
);
    logic [DEPTH-1:0]         ent_valid, ent_ready, ent_fly;
    logic [DEPTH-1:0][1:0]    ent_cause;
    logic [DEPTH-1:0][QW-1:0] ent_idx;

    logic [DEPTH-1:0]  elig, data_mask, free_vec, hot_data, hot_any;
    logic [SLOT_W-1:0] alloc_slot, hold_slot, pick_slot, age_slot;
    logic              enq_fire, acc, win_hit;
    logic [SLOT_W-1:0] win_slot;
    sel_state_t        state, state_nx;
    logic              capture;

    assign enq_ready = ~&ent_valid;
    assign enq_fire  = enq_valid & enq_ready & ~flush;
    assign acc       = (state == S_OFFER) & iss_ready & ~flush;

    always_comb begin
        alloc_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!ent_valid[i]) alloc_slot = SLOT_W'(i);
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i]      = ent_valid[i] & ent_ready[i] & ~ent_fly[i];
            data_mask[i] = elig[i] & (ent_cause[i] == CAUSE_DATA);
            free_vec[i]  = res_valid & ~res_replay & (res_slot == SLOT_W'(i))
                           & ent_valid[i] & ent_fly[i];
        end
    end

    // per-slot state
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    ent_valid[g] <= 1'b0;
                    ent_ready[g] <= 1'b0;
                    ent_fly[g]   <= 1'b0;
                    ent_cause[g] <= '0;
                    ent_idx[g]   <= '0;
                end else if (res_valid && res_slot == SLOT_W'(g)
                             && ent_valid[g] && ent_fly[g]) begin
                    ent_fly[g]   <= 1'b0;
                    ent_ready[g] <= 1'b0;
                    if (res_replay) ent_cause[g] <= res_cause;
                    else            ent_valid[g] <= 1'b0;
                end else if (acc && hold_slot == SLOT_W'(g)) begin
                    ent_fly[g]   <= 1'b1;
                    ent_ready[g] <= 1'b0;
                end else if (enq_fire && alloc_slot == SLOT_W'(g)) begin
                    ent_valid[g] <= 1'b1;
                    ent_ready[g] <= 1'b0;
                    ent_fly[g]   <= 1'b0;
                    ent_cause[g] <= enq_cause;
                    ent_idx[g]   <= enq_idx;
                end else if (wake[g] && ent_valid[g] && !ent_fly[g]) begin
                    ent_ready[g] <= 1'b1;
                end
            end
        end
    endgenerate

    ldrpl_age #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .enq_fire  (enq_fire),
        .enq_slot  (alloc_slot),
        .valid_vec (ent_valid),
        .free_vec  (free_vec),
        .mask_data (data_mask),
        .mask_any  (elig),
        .hot_data  (hot_data),
        .hot_any   (hot_any)
    );

    ldrpl_win #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WIN(WIN)) u_win (
        .elig       (elig),
        .ent_idx    (ent_idx),
        .oldest_ptr (oldest_ptr),
        .hit        (win_hit),
        .slot       (win_slot)
    );

    always_comb begin
        age_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (|data_mask) begin
                if (hot_data[i]) age_slot = SLOT_W'(i);
            end else if (hot_any[i]) begin
                age_slot = SLOT_W'(i);
            end
        end
        pick_slot = win_hit ? win_slot : age_slot;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            hold_slot <= '0;
        end else begin
            state <= state_nx;
            if (capture) hold_slot <= pick_slot;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (!flush && |elig) begin
                    state_nx = S_OFFER;
                    capture  = 1'b1;
                end
            end
            S_OFFER: begin
                if (flush || iss_ready) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        iss_valid = (state == S_OFFER) && !flush;
        iss_slot  = hold_slot;
        iss_idx   = ent_idx[hold_slot];
    end
endmodule

// File: rtl/ldrpl_sel_chk.sv
module ldrpl_sel_chk #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 4,
    parameter int WIN    = 4,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int QW     = IDX_W + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     iss_valid,
    input logic                     iss_ready,
    input logic [SLOT_W-1:0]        iss_slot,
    input logic [QW-1:0]            iss_idx,
    input logic [QW-1:0]            oldest_ptr,
    input logic                     enq_ready,
    input logic [DEPTH-1:0]         elig,
    input logic [DEPTH-1:0]         ent_valid,
    input logic [DEPTH-1:0][QW-1:0] ent_idx,
    input logic [DEPTH-1:0][1:0]    ent_cause
);
    logic exact_any, win_any, data_any;

    always_comb begin
        exact_any = 1'b0;
        win_any   = 1'b0;
        data_any  = 1'b0;
        for (int s = 0; s < DEPTH; s++) begin
            if (elig[s] && ent_cause[s] == 2'd0) data_any = 1'b1;
            if (elig[s] && ent_idx[s] == oldest_ptr) exact_any = 1'b1;
            for (int k = 0; k < WIN; k++)
                if (elig[s] && ent_idx[s] == QW'(oldest_ptr + QW'(k))) win_any = 1'b1;
        end
    end

    AST_ISSUE_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> ent_valid[$past(iss_slot)]); // R2

    AST_EXACT_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(iss_valid) && $past(exact_any)) |-> (iss_idx == $past(oldest_ptr))); // R5

    AST_DATA_CAUSE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(iss_valid) && !$past(win_any) && $past(data_any))
        |-> (ent_cause[iss_slot] == 2'd0)); // R7

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !flush)
        |=> (flush || (iss_valid && $stable(iss_slot) && $stable(iss_idx)))); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (enq_ready && !iss_valid && ent_valid == '0)); // R9
endmodule

bind ldrpl_sel ldrpl_sel_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WIN(WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_slot   (iss_slot),
    .iss_idx    (iss_idx),
    .oldest_ptr (oldest_ptr),
    .enq_ready  (enq_ready),
    .elig       (elig),
    .ent_valid  (ent_valid),
    .ent_idx    (ent_idx),
    .ent_cause  (ent_cause)
);

// File: tb/ldrpl_sel_test.sv
`timescale 1ns/1ps
module ldrpl_sel_test;
    localparam int DEPTH = 8;
    localparam int IDX_W = 4;
    localparam int WIN   = 4;
    localparam int SW    = $clog2(DEPTH);
    localparam int QW    = IDX_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic enq_valid = 1'b0;
    logic [QW-1:0] enq_idx = '0;
    logic [1:0] enq_cause = '0;
    logic enq_ready;
    logic [DEPTH-1:0] wake = '0;
    logic res_valid = 1'b0;
    logic [SW-1:0] res_slot = '0;
    logic res_replay = 1'b0;
    logic [1:0] res_cause = '0;
    logic [QW-1:0] oldest_ptr = '0;
    logic iss_valid;
    logic iss_ready = 1'b0;
    logic [SW-1:0] iss_slot;
    logic [QW-1:0] iss_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldrpl_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WIN(WIN)) uut (.*);

    // {idx slot0, idx slot1, idx slot2, idx slot3, oldest_ptr, expected slot}
    localparam logic [26:0] VEC [0:7] = '{
        {5'd2,  5'd3,  5'd4,  5'd5,  5'd20, 2'd0},  // R4 no window hit
        {5'd2,  5'd3,  5'd4,  5'd5,  5'd4,  2'd2},  // R5 exact match beats age
        {5'd9,  5'd8,  5'd7,  5'd6,  5'd6,  2'd3},  // R5 youngest slot, offset 0
        {5'd9,  5'd8,  5'd3,  5'd6,  5'd7,  2'd1},  // R6 offset 1 over offset 2
        {5'd1,  5'd31, 5'd2,  5'd17, 5'd30, 2'd1},  // R6 wrap, offset 1 over 3
        {5'd1,  5'd0,  5'd2,  5'd17, 5'd30, 2'd1},  // R6 wrap, offset 2 over 3
        {5'd16, 5'd0,  5'd5,  5'd6,  5'd0,  2'd1},  // R6 wrap bit must match
        {5'd3,  5'd2,  5'd1,  5'd0,  5'd0,  2'd3}   // R6 offset 0 in highest slot
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_flush();
        flush = 1'b1; tick(); flush = 1'b0;
    endtask

    task automatic enq(input logic [QW-1:0] idx, input logic [1:0] cause);
        enq_valid = 1'b1; enq_idx = idx; enq_cause = cause;
        tick();
        enq_valid = 1'b0;
    endtask

    task automatic wake_m(input logic [DEPTH-1:0] m);
        wake = m; tick(); wake = '0;
    endtask

    task automatic accept();
        iss_ready = 1'b1; tick(); iss_ready = 1'b0;
    endtask

    task automatic result(input int slot, input bit replay, input logic [1:0] cause);
        res_valid = 1'b1; res_slot = SW'(slot); res_replay = replay; res_cause = cause;
        tick();
        res_valid = 1'b0;
    endtask

    task automatic expect_offer(input int slot, input string req);
        for (int w = 0; w < 8 && !iss_valid; w++) tick();
        check(iss_valid === 1'b1, req, int'(iss_valid), 1);
        check(iss_slot == SW'(slot), req, int'(iss_slot), slot);
    endtask

    task automatic expect_quiet(input string req);
        bit seen = 1'b0;
        for (int w = 0; w < 5; w++) begin
            tick();
            if (iss_valid) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(iss_valid === 1'b0, "R9 reset offer", int'(iss_valid), 0);
        check(enq_ready === 1'b1, "R1 reset free", int'(enq_ready), 1);

        // table walk
        for (int v = 0; v < 8; v++) begin
            do_flush();
            oldest_ptr = VEC[v][6:2];
            enq(VEC[v][26:22], 2'd1);
            enq(VEC[v][21:17], 2'd1);
            enq(VEC[v][16:12], 2'd1);
            enq(VEC[v][11:7],  2'd1);
            wake_m(8'h0F);
            expect_offer(int'(VEC[v][1:0]), $sformatf("R4/R5/R6 row %0d", v));
        end

        // R4 and R8: oldest wakes after younger slots
        do_flush();
        oldest_ptr = 5'd0;
        for (int i = 0; i < 6; i++) enq(QW'(10 + i), 2'd2);
        wake_m(8'b0011_1110);
        expect_offer(1, "R4 oldest ready");
        wake_m(8'b0000_0001);
        tick(); tick();
        check(iss_valid === 1'b1 && iss_slot == SW'(1), "R8 held offer", int'(iss_slot), 1);
        accept();
        expect_offer(0, "R4 late oldest next");

        // R7: data-not-ready cause first
        do_flush();
        enq(5'd10, 2'd1);
        enq(5'd11, 2'd0);
        wake_m(8'b0000_0011);
        expect_offer(1, "R7 data cause first");
        accept();
        expect_offer(0, "R7 other cause after");

        // R1, R2, R3, R10: full pool and replay outcomes
        do_flush();
        for (int i = 0; i < DEPTH; i++) enq(QW'(16 + i), 2'd1);
        check(enq_ready === 1'b0, "R1 full", int'(enq_ready), 0);
        enq(5'd3, 2'd1);
        wake_m(8'b0000_0001);
        expect_offer(0, "R2 offer slot0");
        accept();
        check(enq_ready === 1'b0, "R2 issue keeps slot", int'(enq_ready), 0);
        wake_m(8'b0000_0001);
        expect_quiet("R10 wake in flight");
        result(0, 1'b1, 2'd0);
        expect_quiet("R3 re-arm waits");
        wake_m(8'b0000_0001);
        expect_offer(0, "R3 re-armed offer");
        accept();
        result(0, 1'b0, 2'd0);
        check(enq_ready === 1'b1, "R3 free", int'(enq_ready), 1);
        enq(5'd3, 2'd1);
        check(enq_ready === 1'b0, "R1 lowest free slot", int'(enq_ready), 0);
        wake_m(8'b0000_0001);
        expect_offer(0, "R1 refill slot0");
        check(iss_idx == 5'd3, "R1 stored index", int'(iss_idx), 3);
        accept();

        // R9: flush while an offer is up
        do_flush();
        enq(5'd7, 2'd0);
        enq(5'd8, 2'd0);
        wake_m(8'b0000_0011);
        expect_offer(0, "R9 pre-flush offer");
        flush = 1'b1;
        #1;
        check(iss_valid === 1'b0, "R9 no offer in flush cycle", int'(iss_valid), 1'b0);
        tick();
        flush = 1'b0;
        check(enq_ready === 1'b1, "R9 pool empty", int'(enq_ready), 1);
        wake_m(8'hFF);
        expect_quiet("R9 R10 wake after flush");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule